// File: doc/BRIEF.md
# Byte-Addressed Memory Target for a Two-Wire Serial Bus

This block is an I2C target in front of a 256-location byte array. It takes SCL and SDA through two-flop synchronizers and detects START and STOP from the synchronized lines. It matches the first byte after each START against a 7-bit device address. It then runs one of three transfers. A write sets a word address and streams data bytes. A current-address read streams bytes from a pointer that persists. A random read is a dummy write that sets the pointer, then a repeated START and a read.

The block reads the array through a plain read port. The address output always equals the internal pointer. The array must return data within a few system clocks, which is well inside a half SCL period. Each received data byte goes to a separate commit controller as a one-cycle pulse carrying the address and data. A commit pulse on STOP tells that controller to make the staged bytes permanent. While `busy_i` is high, which means the array is still writing, the block refuses the address byte. A master can therefore poll until the array is free.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, SDA is released and no write or commit pulse is active. A START (SDA falls while SCL is high) at any point restarts address reception. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R2: The first byte after START is received MSB first. Bits [7:1] are compared with `DEV_ADDR`, and bit 0 selects the direction: 0 means write, 1 means read. On a match with `busy_i` low, the block acknowledges by holding SDA low for the ninth clock.
- R3: When the device address does not match, the block never drives SDA until the next START.
- R4: When `busy_i` is high at the end of the address byte, the byte is not acknowledged and the block ignores the bus until the next START.
- R5: In write mode, the second byte loads the pointer. Each later byte is acknowledged and appears for one cycle on `wr_valid_o`, with `wr_addr_o` set to the pointer and `wr_data_o` set to the byte. The pointer then advances by one.
- R6: The pointer wraps from the last location to 0 and keeps its value between transactions.
- R7: In read mode, the byte at the pointer is shifted out MSB first and the pointer advances by one. A read straight after the address byte (current-address read) starts at the stored pointer.
- R8: A write of the device address and a word address, followed by a repeated START and a read, returns the byte at that word address.
- R9: A master ACK on a read byte makes the block send the next sequential byte. A master NACK makes it release SDA and ignore the bus until START or STOP.
- R10: `wr_commit_o` pulses once, on STOP, only when data bytes were written since the previous STOP. A dummy write or a read gives no commit.
- R11: The SDA output enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| busy_i | input | 1 | Array is busy writing; refuse the address byte |
| mem_raddr_o | output | ADDR_W | Read address, equal to the pointer |
| mem_rdata_i | input | 8 | Read data for mem_raddr_o |
| wr_valid_o | output | 1 | One-cycle pulse per received data byte |
| wr_addr_o | output | ADDR_W | Location of the received byte |
| wr_data_o | output | 8 | Received data byte |
| wr_commit_o | output | 1 | One-cycle pulse on STOP after written data |

## Verification
The bench targets pointer wrap in both directions. A write that crosses the last location must land its third byte at 0, and a sequential read must return location 0 after the last one. A design that saturates or skips the pointer breaks the scoreboard order. It also checks that the pointer persists across STOP: a current-address read after a random read must continue where the read stopped. A design that resets the pointer on START would return location 0 instead. A foreign address, an address refused while busy, and a START in the middle of a byte are each checked at the pins. A design that leaks an ACK, stages a write, or loses bit alignment would show a low ACK bit, a stray write pulse or a wrong read byte. The bench also counts commit pulses, so a commit raised by the dummy write of a random read is caught.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RD,
    ST_RACK,
    ST_IGNORE
  } state_e;
endpackage

// File: rtl/i2c_sync_ff.sv
module i2c_sync_ff #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, synced;
  logic              scl_p_q, sda_p_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_sync_ff #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (synced[g])
    );
  end

  assign scl_o = synced[1];
  assign sda_o = synced[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_o;
      sda_p_q <= sda_o;
    end
  end

  assign scl_rise_o = scl_o & ~scl_p_q;
  assign scl_fall_o = ~scl_o & scl_p_q;
  // data edges only count as bus conditions while the clock stays high
  assign start_o    = scl_o & scl_p_q & sda_p_q & ~sda_o;
  assign stop_o     = scl_o & scl_p_q & ~sda_p_q & sda_o;
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + ONE;  // natural wrap at 2**ADDR_W
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_commit_o
);
  localparam logic [CNT_W-1:0] BITS_PER_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE       = CNT_W'(1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_evt),
    .stop_o    (stop_evt)
  );

  state_e              state_q, ret_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BYTE_W-1:0]   rx_sr_q, tx_sr_q;
  logic                oe_q, pend_q, mack_q;
  logic                wr_valid_q, commit_q;
  logic [ADDR_W-1:0]   wr_addr_q;
  logic [BYTE_W-1:0]   wr_data_q;

  logic                byte_done, dev_match, ld_tx, ptr_load, ptr_inc;
  logic [ADDR_W-1:0]   ptr;

  always_comb begin
    byte_done = scl_fall && (cnt_q == BITS_PER_BYTE);
    dev_match = (rx_sr_q[BYTE_W-1:1] == DEV_ADDR);
    ld_tx     = scl_fall && !start_evt && !stop_evt &&
                (((state_q == ST_ACK) && (ret_q == ST_RD)) ||
                 ((state_q == ST_RACK) && mack_q));
    ptr_load  = !start_evt && !stop_evt && (state_q == ST_WADDR) && byte_done;
    ptr_inc   = ld_tx ||
                (!start_evt && !stop_evt && (state_q == ST_WDATA) && byte_done);
  end

  i2c_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ptr_load),
    .load_val_i(rx_sr_q[ADDR_W-1:0]),
    .inc_i     (ptr_inc),
    .ptr_o     (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ret_q      <= ST_IDLE;
      cnt_q      <= '0;
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      oe_q       <= 1'b0;
      pend_q     <= 1'b0;
      mack_q     <= 1'b0;
      wr_valid_q <= 1'b0;
      commit_q   <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_valid_q <= 1'b0;
      commit_q   <= 1'b0;
      if (start_evt) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_evt) begin
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        commit_q <= pend_q;
        pend_q   <= 1'b0;
      end else begin
        if (scl_rise) begin
          if (state_q inside {ST_DEV, ST_WADDR, ST_WDATA}) begin
            rx_sr_q <= {rx_sr_q[BYTE_W-2:0], sda_s};
            cnt_q   <= cnt_q + CNT_ONE;
          end else if (state_q == ST_RD) begin
            cnt_q <= cnt_q + CNT_ONE;
          end else if (state_q == ST_RACK) begin
            mack_q <= ~sda_s;
          end
        end
        if (scl_fall) begin
          unique case (state_q)
            ST_DEV: if (byte_done) begin
              cnt_q <= '0;
              if (dev_match && !busy_i) begin
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
                ret_q   <= rx_sr_q[0] ? ST_RD : ST_WADDR;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
            ST_WADDR: if (byte_done) begin
              cnt_q   <= '0;
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
              ret_q   <= ST_WDATA;
            end
            ST_WDATA: if (byte_done) begin
              cnt_q      <= '0;
              oe_q       <= 1'b1;
              state_q    <= ST_ACK;
              ret_q      <= ST_WDATA;
              wr_valid_q <= 1'b1;
              wr_addr_q  <= ptr;
              wr_data_q  <= rx_sr_q;
              pend_q     <= 1'b1;
            end
            ST_ACK: begin
              state_q <= ret_q;
              oe_q    <= 1'b0;
              if (ret_q == ST_RD) begin
                tx_sr_q <= mem_rdata_i;
                oe_q    <= ~mem_rdata_i[BYTE_W-1];
              end
            end
            ST_RD: begin
              if (cnt_q == BITS_PER_BYTE) begin
                oe_q    <= 1'b0;       // hand SDA to master for its ack bit
                state_q <= ST_RACK;
              end else begin
                tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
                oe_q    <= ~tx_sr_q[BYTE_W-2];
              end
            end
            ST_RACK: begin
              if (mack_q) begin
                tx_sr_q <= mem_rdata_i;
                oe_q    <= ~mem_rdata_i[BYTE_W-1];
                cnt_q   <= '0;
                state_q <= ST_RD;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_raddr_o = ptr;
  assign wr_valid_o  = wr_valid_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign wr_commit_o = commit_q;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              stop_i,
  input logic              sda_oe_i,
  input logic              busy_i,
  input logic              addr_decide_i,
  input logic              ignore_i,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [ADDR_W-1:0] ptr_i,
  input logic              commit_i
);
  assert_quiet_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignore_i |-> !sda_oe_i);

  assert_busy_nack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_decide_i && busy_i) |=> !sda_oe_i);

  assert_ptr_follows_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |-> (ptr_i == ADDR_W'(wr_addr_i + 1'b1)));

  assert_write_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> !wr_valid_i);

  assert_commit_on_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(stop_i));

  assert_oe_moves_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_s_i);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_s_i      (scl_s),
  .stop_i       (stop_evt),
  .sda_oe_i     (sda_oe_o),
  .busy_i       (busy_i),
  .addr_decide_i((state_q == i2c_mem_pkg::ST_DEV) && byte_done && !start_evt && !stop_evt),
  .ignore_i     (state_q == i2c_mem_pkg::ST_IGNORE),
  .wr_valid_i   (wr_valid_o),
  .wr_addr_i    (wr_addr_o),
  .ptr_i        (ptr),
  .commit_i     (wr_commit_o)
);

// File: tb/tb_i2c_mem_target.sv
`timescale 1ns/1ps
module tb_i2c_mem_target;
  localparam int         Q   = 8;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, wr_valid, wr_commit;
  logic [7:0] raddr, rdata, wr_addr, wr_data;
  wire  sda_line = sda_m & ~sda_oe;

  logic [7:0] mem_m [256];
  assign rdata = mem_m[raddr];

  i2c_mem_target #(.DEV_ADDR(DEV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_i(busy), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit)
  );

  int n_chk = 0, n_fail = 0, commit_cnt = 0, bad_r11 = 0;
  bit oe_seen = 0;

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];
  wr_t stage_q[$];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop, commit model, open-drain timing watch
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          wr_t e;
          e = exp_q.pop_front();
          chk({wr_addr, wr_data} == e, "R5 write item", {wr_addr, wr_data}, e);
        end
        stage_q.push_back('{a: wr_addr, d: wr_data});
      end
      if (wr_commit) begin
        commit_cnt++;
        foreach (stage_q[i]) mem_m[stage_q[i].a] = stage_q[i].d;
        stage_q.delete();
      end
      if (sda_oe) oe_seen = 1;
      if (sda_oe !== prev_oe && scl_m) bad_r11++;
      prev_oe = sda_oe;
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_bit(logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic write_txn(logic [7:0] addr, logic [7:0] d0, logic [7:0] d1, logic [7:0] d2);
    logic ack;
    logic [7:0] d [3];
    int c0;
    d[0] = d0; d[1] = d1; d[2] = d2;
    c0 = commit_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R2 address ack (write)", ack, 1);
    send_byte(addr, ack);        chk(ack, "R5 word address ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back('{a: 8'(addr + i), d: d[i]});
      send_byte(d[i], ack); chk(ack, "R5 data ack", ack, 1);
    end
    bus_stop();
    chk(commit_cnt == c0 + 1, "R10 one commit after write", commit_cnt, c0 + 1);
  endtask

  task automatic random_read(logic [7:0] addr, int n);
    logic ack;
    logic [7:0] b;
    int c0;
    c0 = commit_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R8 dummy write ack", ack, 1);
    send_byte(addr, ack);        chk(ack, "R8 word address ack", ack, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R2 address ack (read)", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == mem_m[8'(addr + i)], (i == 0) ? "R8 random read data" : "R9 sequential data",
          b, mem_m[8'(addr + i)]);
    end
    chk(sda_oe == 1'b0, "R9 SDA released after NACK", sda_oe, 0);
    bus_stop();
    chk(commit_cnt == c0, "R10 no commit for dummy write", commit_cnt, c0);
  endtask

  task automatic current_read(logic [7:0] exp_addr);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R7 address ack", ack, 1);
    recv_byte(1'b0, b);
    chk(b == mem_m[exp_addr], "R7 current address data", b, mem_m[exp_addr]);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    int c0;
    for (int i = 0; i < 256; i++) mem_m[i] = 8'(i * 37 + 11);
    repeat (5) @(negedge clk);
    chk(sda_oe == 0 && wr_valid == 0 && wr_commit == 0, "R1 reset state",
        {sda_oe, wr_valid, wr_commit}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    write_txn(8'h10, 8'hA1, 8'hB2, 8'hC3);
    random_read(8'h10, 3);            // pointer ends at 0x13
    current_read(8'h13);              // R6: pointer kept across STOP

    write_txn(8'hFE, 8'h5A, 8'h6B, 8'h7C);  // R6 wrap on write: FE, FF, 00
    random_read(8'hFF, 2);            // R6 wrap on read: FF then 00

    // R3: foreign address
    c0 = commit_cnt;
    bus_start();
    oe_seen = 0;
    send_byte({7'h23, 1'b0}, ack); chk(!ack, "R3 foreign address not acked", ack, 0);
    send_byte(8'h55, ack);         chk(!ack, "R3 later byte not acked", ack, 0);
    chk(!oe_seen, "R3 SDA never driven", oe_seen, 0);
    bus_stop();

    // R4: busy refuses address
    busy = 1'b1;
    bus_start();
    oe_seen = 0;
    send_byte({DEV, 1'b0}, ack); chk(!ack, "R4 busy NACK", ack, 0);
    send_byte(8'h20, ack);       chk(!ack, "R4 ignored after NACK", ack, 0);
    send_byte(8'h99, ack);
    chk(!oe_seen, "R4 SDA never driven", oe_seen, 0);
    bus_stop();
    busy = 1'b0;
    chk(commit_cnt == c0, "R10 no commit while refused", commit_cnt, c0);

    // R1: START in mid-byte restarts address reception
    random_read(8'h40, 1);            // pointer ends at 0x41
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    current_read(8'h41);

    chk(bad_r11 == 0, "R11 SDA enable changes only with SCL low", bad_r11, 0);
    chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule